// File: doc/BRIEF.md
# Bidirectional Width-Matching Queue Bridge

This block joins an 18-bit host port to a 9-bit peripheral port through two independent queues, one per direction. A word the host stores for the peripheral is handed out as two 9-bit lanes, low lane first. Pairs of lanes that arrive from the peripheral are packed into one 18-bit word for the host. Both queues work at the same time.

Each 9-bit lane holds eight data bits in positions [7:0] and a parity position in bit 8. Parity is even: the parity bit equals the XOR of the eight data bits. The bridge builds the parity bit for every lane it sends out. It checks the parity bit of every lane it accepts, and a mismatch sets a sticky error flag that the host clears.

A bypass select sends the low lane of the host's write bus straight to the peripheral output. While bypass is selected, neither queue changes.

Top module: `bidir_width_bridge`

## Requirements
- R1: A host word is accepted when `a_wr_en` is high, bypass is off and `ab_full` is low. On `b_rd_data` the peripheral sees bits [7:0] of the word first, then bits [16:9]. Each accepted `b_rd_en` (bypass off, `ab_empty` low) moves on by one lane, and the word leaves the queue after its second lane has been taken.
- R2: With bypass off and `ba_full` low, the first lane accepted on `b_wr_data` becomes bits [8:0] of a word and the second becomes bits [17:9]. The word enters the host queue on the edge that takes the second lane. `a_rd_data` shows the oldest word, and an accepted `a_rd_en` removes it.
- R3: The two directions run concurrently and independently in any cycle, including cycles that push and pop the same queue.
- R4: Bit 8 of `b_rd_data` always equals the XOR of bits [7:0]. It is built afresh and does not depend on the parity position stored in the word.
- R5: An accepted peripheral lane with odd parity over all 9 bits sets `perr` on the next edge. `perr` then stays high until an edge where `perr_clr` is high and no new error arrives, because a new error wins over a clear.
- R6: While `bypass_en` is high, `b_rd_data` equals {XOR of `a_wr_data[7:0]`, `a_wr_data[7:0]`} in the same cycle. All four enables are ignored, and both queues and both lane-position states keep their values.
- R7: Each queue holds DEPTH words. A write into a full queue and a read from an empty queue are ignored, and so is a peripheral lane offered while `ba_full` is high. An empty queue shows zero on its read-data output.
- R8: Reset (active low, asynchronous) empties both queues, returns both lane-position states to the low lane, drops any half-packed lane and clears `perr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_en | input | 1 | Route host write bus to peripheral output, freeze queues |
| a_wr_en | input | 1 | Host write strobe into the host-to-peripheral queue |
| a_wr_data | input | 18 | Host write word |
| a_rd_en | input | 1 | Host read strobe from the peripheral-to-host queue |
| a_rd_data | output | 18 | Oldest peripheral-to-host word, zero when empty |
| perr_clr | input | 1 | Clear the sticky parity error |
| perr | output | 1 | Sticky parity error |
| ab_empty | output | 1 | Host-to-peripheral queue empty |
| ab_full | output | 1 | Host-to-peripheral queue full |
| ba_empty | output | 1 | Peripheral-to-host queue empty |
| ba_full | output | 1 | Peripheral-to-host queue full |
| b_rd_en | input | 1 | Peripheral takes the current lane |
| b_rd_data | output | 9 | Current outgoing lane with generated parity |
| b_wr_en | input | 1 | Peripheral offers a lane |
| b_wr_data | input | 9 | Incoming lane, parity in bit 8 |

## Verification
`b_rd_data` and `a_rd_data` are combinational views of the queue heads, and in bypass of the host bus, so they are due in the same cycle as the inputs that select them. Pushes, pops, lane-position changes and `perr` take effect on the next rising edge. The bench drives inputs on the falling edge and compares every output with its model 5 ns before the rising edge. It then updates the model with the values that were applied across that edge, so every registered effect is checked one cycle after its cause.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  localparam int LANE_DW = 8;
  localparam int LANE_W  = LANE_DW + 1;
  localparam int WORD_W  = 2 * LANE_W;

  // even parity bit for a lane's data
  function automatic logic lane_par(input logic [LANE_DW-1:0] d);
    return ^d;
  endfunction

  // outgoing lane: data plus freshly built parity
  function automatic logic [LANE_W-1:0] lane_build(input logic [LANE_DW-1:0] d);
    return {lane_par(d), d};
  endfunction

  // incoming lane has even parity over all nine bits
  function automatic logic lane_ok(input logic [LANE_W-1:0] l);
    return (^l) == 1'b0;
  endfunction

  // choose low or high lane of a stored word
  function automatic logic [LANE_W-1:0] lane_pick(input logic [WORD_W-1:0] w,
                                                  input logic hi);
    return hi ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/sync_queue.sv
module sync_queue #(
  parameter int W     = 18,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  // R7: a write into a full queue with no read leaves it full
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  // R7: a read from an empty queue with no write leaves it empty
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/ab_serializer.sv
module ab_serializer
  import bwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              q_empty,
  input  logic [WORD_W-1:0] q_head,
  output logic              pop,
  output logic [LANE_W-1:0] lane
);
  logic hi;
  logic take_ok;
  logic [LANE_W-1:0] raw;

  assign take_ok = take && !q_empty;
  assign pop     = take_ok && hi;
  assign raw     = lane_pick(q_head, hi);
  assign lane    = q_empty ? '0 : lane_build(raw[LANE_DW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi <= 1'b0;
    else if (take_ok) hi <= !hi;
  end

  // R1: after a word leaves, the next word starts at its low lane
  assert_low_after_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !hi);
  // R7: an empty queue does not move the lane position
  assert_hold_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |=> (hi == $past(hi)));
endmodule

// File: rtl/ba_packer.sv
module ba_packer
  import bwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              give,
  input  logic              q_full,
  input  logic [LANE_W-1:0] lane_in,
  input  logic              perr_clr,
  output logic              push,
  output logic [WORD_W-1:0] word,
  output logic              perr
);
  logic              hi;
  logic              give_ok;
  logic              bad;
  logic [LANE_W-1:0] hold;

  assign give_ok = give && !q_full;
  assign push    = give_ok && hi;
  assign word    = {lane_in, hold};
  assign bad     = give_ok && !lane_ok(lane_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi   <= 1'b0;
      hold <= '0;
      perr <= 1'b0;
    end else begin
      if (give_ok) begin
        hi <= !hi;
        if (!hi) hold <= lane_in;
      end
      if (bad)           perr <= 1'b1;
      else if (perr_clr) perr <= 1'b0;
    end
  end

  // R2: a committed word leaves the packer expecting a low lane
  assert_commit_on_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !hi);
  // R5: the error flag holds until cleared
  assert_perr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !perr_clr) |=> perr);
endmodule

// File: rtl/bidir_width_bridge.sv
module bidir_width_bridge
  import bwb_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass_en,
  input  logic              a_wr_en,
  input  logic [WORD_W-1:0] a_wr_data,
  input  logic              a_rd_en,
  output logic [WORD_W-1:0] a_rd_data,
  input  logic              perr_clr,
  output logic              perr,
  output logic              ab_empty,
  output logic              ab_full,
  output logic              ba_empty,
  output logic              ba_full,
  input  logic              b_rd_en,
  output logic [LANE_W-1:0] b_rd_data,
  input  logic              b_wr_en,
  input  logic [LANE_W-1:0] b_wr_data
);
  // named internal events
  logic              ab_push, ab_pop, ba_push, ba_pop;
  logic [WORD_W-1:0] ab_head, ba_word;
  logic [LANE_W-1:0] ser_lane;

  assign ab_push = a_wr_en && !bypass_en;
  assign ba_pop  = a_rd_en && !bypass_en;

  sync_queue #(.W(WORD_W), .DEPTH(DEPTH)) u_ab_q (
    .clk(clk), .rst_n(rst_n),
    .push(ab_push), .push_data(a_wr_data),
    .pop(ab_pop), .head(ab_head),
    .empty(ab_empty), .full(ab_full)
  );

  ab_serializer u_ser (
    .clk(clk), .rst_n(rst_n),
    .take(b_rd_en && !bypass_en),
    .q_empty(ab_empty), .q_head(ab_head),
    .pop(ab_pop), .lane(ser_lane)
  );

  ba_packer u_pack (
    .clk(clk), .rst_n(rst_n),
    .give(b_wr_en && !bypass_en),
    .q_full(ba_full), .lane_in(b_wr_data),
    .perr_clr(perr_clr),
    .push(ba_push), .word(ba_word), .perr(perr)
  );

  sync_queue #(.W(WORD_W), .DEPTH(DEPTH)) u_ba_q (
    .clk(clk), .rst_n(rst_n),
    .push(ba_push), .push_data(ba_word),
    .pop(ba_pop), .head(a_rd_data),
    .empty(ba_empty), .full(ba_full)
  );

  assign b_rd_data = bypass_en ? lane_build(a_wr_data[LANE_DW-1:0]) : ser_lane;

  // R4: every outgoing lane carries even parity
  assert_even_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (^b_rd_data) == 1'b0);
  // R6: a bypass cycle leaves both queues as they were
  assert_bypass_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_en |=> ($stable(ab_empty) && $stable(ab_full) && $stable(ba_empty)
                   && $stable(ba_full) && $stable(a_rd_data)));
  // R2: the packer only commits into a queue with room
  assert_commit_has_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ba_push |-> !ba_full);
endmodule

// File: tb/bidir_width_bridge_bench.sv
module bidir_width_bridge_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass_en = 0, a_wr_en = 0, a_rd_en = 0, perr_clr = 0;
  logic        b_rd_en = 0, b_wr_en = 0;
  logic [17:0] a_wr_data = '0;
  logic [8:0]  b_wr_data = '0;
  logic [17:0] a_rd_data;
  logic [8:0]  b_rd_data;
  logic        perr, ab_empty, ab_full, ba_empty, ba_full;

  int errors = 0;
  int checks = 0;
  string cur_req = "R8";

  // behavioural model
  logic [17:0] ab_q[$];
  logic [17:0] ba_q[$];
  bit          m_ab_hi = 0, m_ba_hi = 0, m_perr = 0;
  logic [8:0]  m_hold = '0;

  always #10 clk = ~clk;

  bidir_width_bridge #(.DEPTH(DEPTH)) u_bidir_width_bridge (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en),
    .a_wr_en(a_wr_en), .a_wr_data(a_wr_data),
    .a_rd_en(a_rd_en), .a_rd_data(a_rd_data),
    .perr_clr(perr_clr), .perr(perr),
    .ab_empty(ab_empty), .ab_full(ab_full),
    .ba_empty(ba_empty), .ba_full(ba_full),
    .b_rd_en(b_rd_en), .b_rd_data(b_rd_data),
    .b_wr_en(b_wr_en), .b_wr_data(b_wr_data)
  );

  function automatic logic [8:0] good_lane(input logic [7:0] d);
    return {^d, d};
  endfunction

  function automatic logic [8:0] bad_lane(input logic [7:0] d);
    return {~^d, d};
  endfunction

  task automatic chk(input string name, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", cur_req, name, act, exp);
    end
  endtask

  task automatic compare();
    logic [17:0] e_a;
    logic [8:0]  e_b, l;
    e_a = (ba_q.size() == 0) ? 18'h0 : ba_q[0];
    if (bypass_en) e_b = good_lane(a_wr_data[7:0]);
    else if (ab_q.size() == 0) e_b = 9'h0;
    else begin
      l   = m_ab_hi ? ab_q[0][17:9] : ab_q[0][8:0];
      e_b = good_lane(l[7:0]);
    end
    chk("b_rd_data", {9'h0, b_rd_data}, {9'h0, e_b});
    chk("a_rd_data", a_rd_data, e_a);
    chk("ab_empty", {17'h0, ab_empty}, {17'h0, ab_q.size() == 0});
    chk("ab_full",  {17'h0, ab_full},  {17'h0, ab_q.size() == DEPTH});
    chk("ba_empty", {17'h0, ba_empty}, {17'h0, ba_q.size() == 0});
    chk("ba_full",  {17'h0, ba_full},  {17'h0, ba_q.size() == DEPTH});
    chk("perr", {17'h0, perr}, {17'h0, m_perr});
  endtask

  task automatic model_update();
    int abn, ban;
    bit bad_in;
    abn = ab_q.size();
    ban = ba_q.size();
    bad_in = 0;
    if (!bypass_en) begin
      if (b_rd_en && abn > 0) begin
        if (m_ab_hi) begin void'(ab_q.pop_front()); m_ab_hi = 0; end
        else m_ab_hi = 1;
      end
      if (a_wr_en && abn < DEPTH) ab_q.push_back(a_wr_data);
      if (a_rd_en && ban > 0) void'(ba_q.pop_front());
      if (b_wr_en && ban < DEPTH) begin
        bad_in = ^b_wr_data;
        if (m_ba_hi) begin ba_q.push_back({b_wr_data, m_hold}); m_ba_hi = 0; end
        else begin m_hold = b_wr_data; m_ba_hi = 1; end
      end
    end
    if (bad_in) m_perr = 1;
    else if (perr_clr) m_perr = 0;
  endtask

  task automatic step(input bit aw, input logic [17:0] awd, input bit ar,
                      input bit br, input bit bw, input logic [8:0] bwd,
                      input bit byp, input bit clr);
    @(negedge clk);
    a_wr_en = aw; a_wr_data = awd; a_rd_en = ar; b_rd_en = br;
    b_wr_en = bw; b_wr_data = bwd; bypass_en = byp; perr_clr = clr;
    #5;
    compare();
    @(posedge clk);
    model_update();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    a_wr_en = 0; a_rd_en = 0; b_rd_en = 0; b_wr_en = 0;
    bypass_en = 0; perr_clr = 0;
    ab_q.delete(); ba_q.delete();
    m_ab_hi = 0; m_ba_hi = 0; m_perr = 0; m_hold = '0;
    #5;
    compare();
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur_req = "R8";
    do_reset();
    step(0, 0, 0, 0, 0, 0, 0, 0);

    // R1: lane order low then high, pop after high lane
    cur_req = "R1";
    step(1, {good_lane(8'hA1), good_lane(8'h12)}, 0, 0, 0, 0, 0, 0);
    step(1, {good_lane(8'h3C), good_lane(8'hC3)}, 0, 0, 0, 0, 0, 0);
    step(1, {good_lane(8'hFF), good_lane(8'h00)}, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 0, 0, 0, 0);

    // R4: stored parity positions are wrong, output parity is rebuilt
    cur_req = "R4";
    step(1, 18'h3FFFF, 0, 0, 0, 0, 0, 0);
    step(1, 18'h00100, 0, 0, 0, 0, 0, 0);
    step(1, {1'b0, 8'h01, 1'b0, 8'h80}, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0, 0, 0);

    // R2: packing low then high, commit on the second lane
    cur_req = "R2";
    step(0, 0, 0, 0, 1, good_lane(8'h5A), 0, 0);
    step(0, 0, 0, 0, 1, good_lane(8'h96), 0, 0);
    step(0, 0, 0, 0, 1, good_lane(8'h07), 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, good_lane(8'hE0), 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);

    // R3: both directions at once
    cur_req = "R3";
    for (int i = 0; i < 80; i++)
      step($urandom % 2, 18'($urandom), $urandom % 2, $urandom % 2,
           $urandom % 2, good_lane(8'($urandom)), 0, 0);

    // R5: sticky parity error, error wins over clear
    cur_req = "R5";
    step(0, 0, 0, 0, 1, bad_lane(8'h33), 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, bad_lane(8'h40), 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, good_lane(8'h41), 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);

    // R6: bypass with partial states pending
    cur_req = "R6";
    step(1, {good_lane(8'h11), good_lane(8'h22)}, 0, 0, 0, 0, 0, 0);
    step(1, {good_lane(8'h33), good_lane(8'h44)}, 0, 1, 1, good_lane(8'h55), 0, 0);
    for (int i = 0; i < 6; i++)
      step(1, 18'($urandom), 1, 1, 1, bad_lane(8'($urandom)), 1, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, good_lane(8'h66), 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);

    // R7: overflow and underflow in both directions
    cur_req = "R7";
    for (int i = 0; i < DEPTH + 4; i++) step(1, 18'($urandom), 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2 * DEPTH + 4; i++) step(0, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 2 * DEPTH + 3; i++)
      step(0, 0, 0, 0, 1, good_lane(8'(i * 7 + 1)), 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, good_lane(8'hAB), 0, 0);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 0, 0, 0, 0, 0);

    // R8: reset drops a half-packed lane and a half-sent word
    cur_req = "R8";
    step(1, {good_lane(8'h77), good_lane(8'h88)}, 0, 0, 1, good_lane(8'h99), 0, 0);
    step(0, 0, 0, 1, 1, bad_lane(8'h01), 0, 0);
    do_reset();
    step(0, 0, 0, 0, 1, good_lane(8'hC1), 0, 0);
    step(1, {good_lane(8'hD4), good_lane(8'hD3)}, 0, 0, 1, good_lane(8'hC2), 0, 0);
    step(0, 0, 1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule